// File: doc/BRIEF.md
# Signed-digit redundant binary to two's complement converter

This block turns an N-digit signed-digit redundant number into an (N+1)-bit two's complement integer. It is purely combinational. Each digit is a pair of bits whose value is the sum of the two bits minus one. The block splits the word into two bit-planes. It reads each plane as an unsigned N-bit word, zero-extends both to N+1 bits and adds them with one ordinary binary adder. The adder's carry input supplies the constant +1. The remaining constant, minus two to the power N, is applied by flipping the most significant bit of the sum. Because the only arithmetic is a plain `a + b + cin`, synthesis can map it onto the device's dedicated carry chain.

A companion path converts an N-bit two's complement integer into redundant form. Each bit becomes one digit, with no arithmetic. A datapath that computes in redundant form can use the forward path to enter its values and the main path to leave.

Top module: `rbr_to_twos`

## Requirements
- R1: Digit k of `rd_in` occupies bits [2k+1:2k]. The two-bit codes map as follows: 2'b00 is -1, 2'b01 is 0, 2'b10 is 0, 2'b11 is +1. `tc_out` equals the sum of digit_k * 2^k as a two's complement value (N+1 bits), within the same cycle the input is applied.
- R2: Both zero codes (2'b01 and 2'b10) contribute nothing in any mix. A word built only from them gives `tc_out` = 0.
- R3: All digits 2'b11 give +(2^N-1), and all digits 2'b00 give -(2^N-1). These are the two ends of the output range.
- R4: `tc_out` never shows the code with only the MSB set (-2^N), and the internal adder never carries out of N+1 bits.
- R5: In `rd_out`, every non-sign bit k (k < N-1) of `tc_in` becomes digit 2'b01 when the bit is 0 and 2'b11 when the bit is 1.
- R6: In `rd_out`, the sign bit of `tc_in` becomes digit 2'b00 (-1) when set and 2'b01 when clear, at digit position N-1.
- R7: Feeding `rd_out` back into `rd_in` yields `tc_out` equal to `tc_in` sign-extended to N+1 bits, including -2^(N-1) and 2^(N-1)-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_in | input | 2*N | Redundant number, two bits per digit, digit 0 in the low pair |
| tc_out | output | N+1 | Two's complement value of `rd_in` |
| tc_in | input | N | Two's complement integer for the companion path |
| rd_out | output | 2*N | Redundant encoding of `tc_in` |

## Verification
Since the block holds no state, a wrong plane split, a missing carry-in or an unflipped sign bit shows at `tc_out` in the same cycle as the input. The likely symptoms are an off-by-one, an offset of 2^N, or a value that depends on which zero code was used. The extremes (all +1, all -1, all-zero words in either zero code) separate an error in the constant term from an error in the digit weights. Round-trip vectors tie the two paths together: a fault in the sign-digit mapping of the forward path shows as a result off by 2^N for negative inputs only.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  // Two-bit digit codes; value of a digit is hi + lo - 1.
  typedef enum logic [1:0] {
    DIG_NEG = 2'b00,
    DIG_ZLO = 2'b01,
    DIG_ZHI = 2'b10,
    DIG_POS = 2'b11
  } rbr_digit_e;

  // Signed contribution of one digit code, as a small integer.
  function automatic int digit_value(input logic [1:0] code);
    int v;
    unique case (code)
      DIG_NEG: v = -1;
      DIG_POS: v = 1;
      default: v = 0;
    endcase
    return v;
  endfunction

  // Digit code for an ordinary (positive weight) two's complement bit.
  function automatic logic [1:0] plain_bit_digit(input logic b);
    return b ? DIG_POS : DIG_ZLO;
  endfunction

  // Digit code for the negative-weight sign bit.
  function automatic logic [1:0] sign_bit_digit(input logic b);
    return b ? DIG_NEG : DIG_ZLO;
  endfunction

endpackage

// File: rtl/rbr_plane_split.sv
module rbr_plane_split #(
  parameter int N = 16,
  localparam int W = N + 1
) (
  input  logic [2*N-1:0] word_in,
  output logic [W-1:0]   plane_hi,
  output logic [W-1:0]   plane_lo
);

  // Each digit pair contributes one bit to each unsigned plane.
  for (genvar k = 0; k < N; k++) begin : g_digit
    assign plane_hi[k] = word_in[2*k+1];
    assign plane_lo[k] = word_in[2*k];
  end

  // Zero extension to the adder width.
  assign plane_hi[N] = 1'b0;
  assign plane_lo[N] = 1'b0;

  always_comb begin
    AST_PLANES_KEEP_ONES: assert ($countones(plane_hi) + $countones(plane_lo) == $countones(word_in))
      else $error("plane split lost or invented set bits"); // R1
  end

endmodule

// File: rtl/rbr_carry_add.sv
module rbr_carry_add #(
  parameter int W = 17
) (
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  input  logic         add_cin,
  output logic [W-1:0] add_sum,
  output logic         add_cout
);

  // Plain ripple-style expression so the carry chain can be inferred.
  assign {add_cout, add_sum} = {1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, add_cin};

endmodule

// File: rtl/tc_to_rbr.sv
module tc_to_rbr #(
  parameter int N = 16
) (
  input  logic [N-1:0]   tc_word,
  output logic [2*N-1:0] rd_word
);
  import rbr_pkg::*;

  for (genvar k = 0; k < N; k++) begin : g_bit
    if (k == N - 1) begin : g_sign
      assign rd_word[2*k +: 2] = sign_bit_digit(tc_word[k]);
    end else begin : g_plain
      assign rd_word[2*k +: 2] = plain_bit_digit(tc_word[k]);
    end
  end

endmodule

// File: rtl/rbr_to_twos.sv
module rbr_to_twos #(
  parameter int N = 16
) (
  input  logic [2*N-1:0] rd_in,
  output logic [N:0]     tc_out,
  input  logic [N-1:0]   tc_in,
  output logic [2*N-1:0] rd_out
);
  import rbr_pkg::*;

  localparam int W = N + 1;

  // Digit-by-digit weighted sum, used only by the checks below.
  function automatic logic signed [W-1:0] serial_value(input logic [2*N-1:0] w);
    logic signed [W-1:0] acc;
    logic signed [W-1:0] term;
    acc = '0;
    for (int k = 0; k < N; k++) begin
      term = W'(1) << k;
      case (digit_value(w[2*k +: 2]))
        1:       acc = acc + term;
        -1:      acc = acc - term;
        default: acc = acc;
      endcase
    end
    return acc;
  endfunction

  function automatic logic [W-1:0] sign_extend(input logic [N-1:0] v);
    return {v[N-1], v};
  endfunction

  // Named internal wires for the checks.
  logic [W-1:0] plane_hi;
  logic [W-1:0] plane_lo;
  logic [W-1:0] raw_sum;
  logic         raw_cout;

  rbr_plane_split #(.N(N)) u_split (
    .word_in  (rd_in),
    .plane_hi (plane_hi),
    .plane_lo (plane_lo)
  );

  // The constant +1 of the identity enters through the carry input.
  rbr_carry_add #(.W(W)) u_add (
    .add_a    (plane_hi),
    .add_b    (plane_lo),
    .add_cin  (1'b1),
    .add_sum  (raw_sum),
    .add_cout (raw_cout)
  );

  // Subtracting 2^N modulo 2^(N+1) is a flip of the top bit.
  assign tc_out = {~raw_sum[N], raw_sum[N-1:0]};

  tc_to_rbr #(.N(N)) u_fwd (
    .tc_word (tc_in),
    .rd_word (rd_out)
  );

  always_comb begin
    AST_SUM_MATCHES_DIGITS: assert (tc_out == serial_value(rd_in))
      else $error("converted value differs from digit sum"); // R1
    AST_NO_CARRY_OUT: assert (!raw_cout)
      else $error("plane adder overflowed"); // R4
    AST_NOT_MIN_CODE: assert (tc_out != {1'b1, {N{1'b0}}})
      else $error("output reached -2^N"); // R4
    AST_ROUNDTRIP: assert (serial_value(rd_out) == sign_extend(tc_in))
      else $error("forward encoding does not decode back"); // R7
  end

endmodule

// File: tb/sim_rbr_to_twos.sv
module sim_rbr_to_twos;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2*N-1:0] rd_in = '0;
  logic [N:0]     tc_out;
  logic [N-1:0]   tc_in = '0;
  logic [2*N-1:0] rd_out;

  rbr_to_twos #(.N(N)) u0 (
    .rd_in  (rd_in),
    .tc_out (tc_out),
    .tc_in  (tc_in),
    .rd_out (rd_out)
  );

  typedef struct {
    logic [N:0]     exp_s;
    logic [2*N-1:0] exp_r;
    string          tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Independent model: weight each pair by its code.
  function automatic logic [N:0] model_value(input logic [2*N-1:0] w);
    longint v = 0;
    for (int k = 0; k < N; k++) begin
      if (w[2*k +: 2] == 2'b11) v += (64'sd1 <<< k);
      else if (w[2*k +: 2] == 2'b00) v -= (64'sd1 <<< k);
    end
    return v[N:0];
  endfunction

  function automatic logic [2*N-1:0] model_encode(input logic [N-1:0] t);
    logic [2*N-1:0] w;
    for (int k = 0; k < N; k++) begin
      if (k == N - 1) w[2*k +: 2] = t[k] ? 2'b00 : 2'b01;
      else            w[2*k +: 2] = t[k] ? 2'b11 : 2'b01;
    end
    return w;
  endfunction

  task automatic send(input logic [2*N-1:0] r, input logic [N-1:0] t, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    rd_in = r;
    tc_in = t;
    it.exp_s = model_value(r);
    it.exp_r = model_encode(t);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compare away from the rising edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (tc_out !== it.exp_s) begin
        errors++;
        $display("FAIL %s tc_out actual=%0h expected=%0h (rd_in=%0h)", it.tag, tc_out, it.exp_s, rd_in);
      end
      checks++;
      if (rd_out !== it.exp_r) begin
        errors++;
        $display("FAIL %s rd_out actual=%0h expected=%0h (tc_in=%0h)", it.tag, rd_out, it.exp_r, tc_in);
      end
      checks++;
      if (tc_out === {1'b1, {N{1'b0}}}) begin
        errors++;
        $display("FAIL R4 tc_out actual=%0h expected=not %0h", tc_out, {1'b1, {N{1'b0}}});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] t;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Zeroed inputs after reset: all digits -1, forward of 0.
    send('0, '0, "R3 reset/all-neg");
    send({N{2'b01}}, '0, "R2 all-01");
    send({N{2'b10}}, '0, "R2 all-10");
    send({(N/2){4'b0110}}, '0, "R2 mixed-zero");
    send({N{2'b11}}, {N{1'b1}}, "R3 all-pos / R5 ones");
    send({2'b11, {(N-1){2'b01}}}, {1'b1, {(N-1){1'b0}}}, "R1 top-digit / R6 min");
    send({{(N-1){2'b01}}, 2'b00}, {1'b0, {(N-1){1'b1}}}, "R1 low-neg / R6 max");
    for (int i = 0; i < 300; i++) begin
      send({$urandom, $urandom}, N'($urandom), "R1 random / R5");
    end
    // Round trips, extremes first.
    t = {1'b1, {(N-1){1'b0}}}; send(model_encode(t), t, "R7 min");
    t = {1'b0, {(N-1){1'b1}}}; send(model_encode(t), t, "R7 max");
    t = '0;                    send(model_encode(t), t, "R7 zero");
    t = {N{1'b1}};             send(model_encode(t), t, "R7 minus-one");
    for (int i = 0; i < 200; i++) begin
      t = N'($urandom);
      send(model_encode(t), t, "R7 random / R6");
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    finish_run();
  end

endmodule